// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block drives the address side of a multi-word register transfer. A caller presents a base address, a register-select mask, an addressing mode, a load/store direction and a writeback enable, then pulses `start`. After two fixed overhead cycles, the sequencer issues one word request per selected register over a valid/ready handshake. Each request carries a word-aligned address and the index of the register that owns that word. When the last beat has been accepted, it raises a one-cycle completion pulse together with the updated base value.

Four addressing modes are supported: ascending after, ascending before, descending after and descending before. Stack-style requests are also accepted. In that case a full/empty and ascending/descending stack kind is combined with the direction and translated into one of the four modes. In every mode the beats run from the lowest selected register to the highest, at rising addresses. The mode only decides where the first word lies and where the written-back base ends. Once started, a transfer cannot be restarted or interrupted. A second `start` while busy is ignored, and the completion pulse is the point at which a caller may service pending events.

Top module: `blkxfer_seq`

## Requirements
- R1: After `start` is accepted in idle, `busy` is high and `req_valid` is low for exactly two cycles before the first beat (or the completion pulse, for an empty mask). A transfer therefore occupies 2 + (beat cycles) cycles of `busy`.
- R2: Mode code 0 (ascending after): the first address is the base, and each following beat is 4 higher.
- R3: Mode code 1 (ascending before): the first address is base+4, and each following beat is 4 higher. The word at the base is skipped.
- R4: Mode code 2 (descending after): the first address is base - 4*N + 4, where N is the number of set mask bits. Addresses then rise by 4 per beat.
- R5: Mode code 3 (descending before): the first address is base - 4*N. Addresses then rise by 4 per beat.
- R6: `req_idx` walks the set bits of the mask from lowest to highest, so the lowest-numbered register always takes the lowest address. There is exactly one beat per set bit.
- R7: While `req_valid` is high and `req_ready` is low, `req_addr`, `req_idx` and `req_write` hold their values. A beat advances only on a cycle where both are high.
- R8: At the completion pulse, `new_base` is base + 4*N for the ascending modes and base - 4*N for the descending modes when writeback is enabled, or the base itself when it is not. `wb_valid` equals the latched writeback enable.
- R9: With `stack_en` high, `stack_kind` bit 1 selects ascending (1) or descending (0) and bit 0 selects empty (1) or full (0). Pops (`is_load`=1) map to: full-descending → 0, full-ascending → 2, empty-descending → 1, empty-ascending → 3. Pushes use the opposite mode in both direction and before/after (mode XOR 3).
- R10: An all-zero mask issues no beats, completes right after the two overhead cycles, and returns the base unchanged.
- R11: Bits 1:0 of `req_addr` are always zero, whatever the low bits of the base are.
- R12: A `start` pulse while `busy` is high has no effect on the running transfer. No further transfer follows it.
- R13: `done` lasts exactly one cycle, with `busy` low, right after the cycle in which the last beat is accepted. `req_write` is the inverse of the latched `is_load`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer; accepted only when idle |
| base | input | ADDR_W | Base address |
| reg_mask | input | NREG | Register-select mask, bit i selects register i |
| mode | input | 2 | Addressing mode: bit 1 = descending, bit 0 = before |
| stack_en | input | 1 | Use stack-kind translation instead of `mode` |
| stack_kind | input | 2 | Bit 1 ascending, bit 0 empty |
| is_load | input | 1 | 1 = load (pop), 0 = store (push) |
| wb_en | input | 1 | Write the updated base back |
| req_valid | output | 1 | A word request is presented |
| req_ready | input | 1 | Memory accepts the presented request |
| req_addr | output | ADDR_W | Word-aligned request address |
| req_idx | output | IDX_W | Register index of the current beat |
| req_write | output | 1 | Request is a store |
| busy | output | 1 | Transfer in progress (overhead or beats) |
| done | output | 1 | One-cycle completion pulse |
| new_base | output | ADDR_W | Updated base, valid at `done` |
| wb_valid | output | 1 | Base writeback requested, valid at `done` |

## Verification
All four modes are swept with masks that are empty, a single low bit, a single high bit, a contiguous run, an alternating pattern and full. With one bit, every mode's start offset is exposed on its own. The full and sparse masks separate the N-dependent descending offsets and check the ascending index walk. Each pattern runs with and without writeback and with `req_ready` held high or toggling, so that the overhead count, stall hold and beat count are not confused with each other. The stack-kind pairs replay a store-before/load-after round trip and both pop and push of all four stack kinds. A mid-transfer `start` with different arguments shows that the latched arguments are kept.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;
   typedef enum logic [1:0] {
      AM_ASC_AFTER   = 2'd0,
      AM_ASC_BEFORE  = 2'd1,
      AM_DESC_AFTER  = 2'd2,
      AM_DESC_BEFORE = 2'd3
   } addr_mode_t;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_OVH1 = 3'd1,
      ST_OVH2 = 3'd2,
      ST_BEAT = 3'd3,
      ST_DONE = 3'd4
   } seq_state_t;

   function automatic logic mode_is_desc(input addr_mode_t m);
      return m[1];
   endfunction

   function automatic logic mode_is_before(input addr_mode_t m);
      return m[0];
   endfunction
endpackage

// File: rtl/blkxfer_mode_map.sv
module blkxfer_mode_map
   import blkxfer_pkg::*;
(
   input  logic       stack_en,
   input  logic [1:0] stack_kind,
   input  logic       is_load,
   input  logic [1:0] mode_in,
   output addr_mode_t mode_out
);
   addr_mode_t pop_mode;

   always_comb begin
      unique case (stack_kind)
         2'b00:   pop_mode = AM_ASC_AFTER;    // full descending
         2'b10:   pop_mode = AM_DESC_AFTER;   // full ascending
         2'b01:   pop_mode = AM_ASC_BEFORE;   // empty descending
         default: pop_mode = AM_DESC_BEFORE;  // empty ascending
      endcase
   end

   always_comb begin
      if (!stack_en)
         mode_out = addr_mode_t'(mode_in);
      else if (is_load)
         mode_out = pop_mode;
      else
         mode_out = addr_mode_t'(pop_mode ^ 2'b11);
   end
endmodule

// File: rtl/blkxfer_popcnt.sv
module blkxfer_popcnt #(
   parameter int NREG  = 16,
   parameter int CNT_W = $clog2(NREG + 1)
) (
   input  logic [NREG-1:0]  vec,
   output logic [CNT_W-1:0] cnt
);
   always_comb begin
      cnt = '0;
      for (int i = 0; i < NREG; i++)
         cnt = cnt + CNT_W'(vec[i]);
   end
endmodule

// File: rtl/blkxfer_lowbit.sv
module blkxfer_lowbit #(
   parameter int NREG  = 16,
   parameter int IDX_W = $clog2(NREG)
) (
   input  logic [NREG-1:0]  vec,
   output logic [IDX_W-1:0] idx,
   output logic             any
);
   always_comb begin
      idx = '0;
      for (int i = NREG - 1; i >= 0; i--)
         if (vec[i]) idx = IDX_W'(i);
   end
   assign any = |vec;
endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
   import blkxfer_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int NREG   = 16,
   parameter int IDX_W  = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] base,
   input  logic [NREG-1:0]   reg_mask,
   input  logic [1:0]        mode,
   input  logic              stack_en,
   input  logic [1:0]        stack_kind,
   input  logic              is_load,
   input  logic              wb_en,
   output logic              req_valid,
   input  logic              req_ready,
   output logic [ADDR_W-1:0] req_addr,
   output logic [IDX_W-1:0]  req_idx,
   output logic              req_write,
   output logic              busy,
   output logic              done,
   output logic [ADDR_W-1:0] new_base,
   output logic              wb_valid
);
   localparam int CNT_W = $clog2(NREG + 1);

   if (NREG < 2) begin : g_bad_nreg
      $error("NREG must be at least 2");
   end
   if (ADDR_W < CNT_W + 3) begin : g_bad_addr
      $error("ADDR_W too narrow for the span of a full transfer");
   end

   addr_mode_t  eff_mode;
   logic [CNT_W-1:0]  n_set;
   logic [ADDR_W-1:0] span;
   logic [ADDR_W-1:0] first_addr;
   logic [ADDR_W-1:0] end_base;

   seq_state_t        state_q;
   logic [NREG-1:0]   rem_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] nbase_q;
   logic              write_q;
   logic              wb_q;
   logic              low_any;
   logic [IDX_W-1:0]  low_idx;
   logic              accept, beat_fire, last_beat;

   blkxfer_mode_map u_map (
      .stack_en  (stack_en),
      .stack_kind(stack_kind),
      .is_load   (is_load),
      .mode_in   (mode),
      .mode_out  (eff_mode)
   );

   blkxfer_popcnt #(.NREG(NREG), .CNT_W(CNT_W)) u_cnt (
      .vec(reg_mask),
      .cnt(n_set)
   );

   blkxfer_lowbit #(.NREG(NREG), .IDX_W(IDX_W)) u_low (
      .vec(rem_q),
      .idx(low_idx),
      .any(low_any)
   );

   assign span = ADDR_W'(n_set) << 2;

   always_comb begin
      unique case (eff_mode)
         AM_ASC_AFTER:   first_addr = base;
         AM_ASC_BEFORE:  first_addr = base + ADDR_W'(4);
         AM_DESC_AFTER:  first_addr = base - span + ADDR_W'(4);
         default:        first_addr = base - span;
      endcase
      if (!wb_en)
         end_base = base;
      else if (mode_is_desc(eff_mode))
         end_base = base - span;
      else
         end_base = base + span;
   end

   assign accept    = start && (state_q == ST_IDLE);
   assign beat_fire = (state_q == ST_BEAT) && req_ready;
   assign last_beat = (rem_q & (rem_q - NREG'(1))) == '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         rem_q   <= '0;
         addr_q  <= '0;
         nbase_q <= '0;
         write_q <= 1'b0;
         wb_q    <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (accept) begin
               state_q <= ST_OVH1;
               rem_q   <= reg_mask;
               addr_q  <= first_addr;
               nbase_q <= end_base;
               write_q <= !is_load;
               wb_q    <= wb_en;
            end
            ST_OVH1: state_q <= ST_OVH2;
            ST_OVH2: state_q <= low_any ? ST_BEAT : ST_DONE;
            ST_BEAT: if (beat_fire) begin
               rem_q  <= rem_q & (rem_q - NREG'(1));
               addr_q <= addr_q + ADDR_W'(4);
               if (last_beat) state_q <= ST_DONE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_valid = (state_q == ST_BEAT);
   assign req_addr  = {addr_q[ADDR_W-1:2], 2'b00};
   assign req_idx   = low_idx;
   assign req_write = write_q;
   assign busy      = (state_q == ST_OVH1) || (state_q == ST_OVH2) || (state_q == ST_BEAT);
   assign done      = (state_q == ST_DONE);
   assign new_base  = nbase_q;
   assign wb_valid  = wb_q;

   a_r1_overhead: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && !done) |=> (busy && !req_valid) ##1 (busy && !req_valid));

   a_r6_index_rises: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) ##1 req_valid |->
         (req_idx > $past(req_idx)) && (req_addr == $past(req_addr) + ADDR_W'(4)));

   a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=>
         (req_valid && $stable(req_addr) && $stable(req_idx) && $stable(req_write)));

   a_r11_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_addr[1:0] == 2'b00));

   a_r13_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !req_valid) ##1 !done);

   a_r13_single_state: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({busy, done}));
endmodule

// File: tb/blkxfer_seq_test.sv
module blkxfer_seq_test;
   localparam int PERIOD = 10;
   localparam int AW = 32;
   localparam int NR = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [AW-1:0] base = '0;
   logic [NR-1:0] reg_mask = '0;
   logic [1:0] mode = '0;
   logic stack_en = 1'b0;
   logic [1:0] stack_kind = '0;
   logic is_load = 1'b0;
   logic wb_en = 1'b0;
   logic req_valid, req_ready = 1'b0;
   logic [AW-1:0] req_addr;
   logic [3:0] req_idx;
   logic req_write, busy, done, wb_valid;
   logic [AW-1:0] new_base;

   int checks = 0;
   int fails  = 0;

   always #(PERIOD/2) clk = ~clk;

   blkxfer_seq #(.ADDR_W(AW), .NREG(NR)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .base(base), .reg_mask(reg_mask),
      .mode(mode), .stack_en(stack_en), .stack_kind(stack_kind), .is_load(is_load),
      .wb_en(wb_en), .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .req_idx(req_idx), .req_write(req_write), .busy(busy), .done(done),
      .new_base(new_base), .wb_valid(wb_valid)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic string mode_tag(input int m);
      case (m)
         0: return "R2";
         1: return "R3";
         2: return "R4";
         default: return "R5";
      endcase
   endfunction

   // expected mode for stack requests, from the R9 table
   function automatic int stack_mode(input int kind, input bit load);
      int pop;
      case (kind)
         0: pop = 0;
         2: pop = 2;
         1: pop = 1;
         default: pop = 3;
      endcase
      return load ? pop : (pop ^ 3);
   endfunction

   task automatic run(input logic [AW-1:0] b, input logic [NR-1:0] m, input int md,
                      input bit sten, input int kind, input bit ld, input bit wb,
                      input bit stall, input bit inject, output logic [AW-1:0] nb_out);
      int n = 0;
      int em;
      logic [AW-1:0] first, exp_nb;
      int idxs[NR];
      int k = 0, vcyc = 0, cyc = 0;
      bit seen_done = 0;
      for (int i = 0; i < NR; i++) if (m[i]) begin idxs[n] = i; n++; end
      em = sten ? stack_mode(kind, ld) : md;
      case (em)
         0: first = b;
         1: first = b + 4;
         2: first = b - 4*n + 4;
         default: first = b - 4*n;
      endcase
      exp_nb = !wb ? b : (em >= 2 ? b - 4*n : b + 4*n);
      @(negedge clk);
      base = b; reg_mask = m; mode = 2'(md); stack_en = sten; stack_kind = 2'(kind);
      is_load = ld; wb_en = wb; start = 1'b1; req_ready = 1'b0;
      @(negedge clk);
      start = 1'b0;
      chk(busy && !req_valid, "R1 overhead cycle 1", {busy, req_valid}, 2'b10);
      @(negedge clk);
      chk(busy && !req_valid, "R1 overhead cycle 2", {busy, req_valid}, 2'b10);
      while (cyc < 200) begin
         @(negedge clk);
         cyc++;
         if (inject) start = 1'b0;
         if (done) begin seen_done = 1; break; end
         if (req_valid) begin
            vcyc++;
            if (k < n) begin
               chk(req_addr == ((first + 4*k) & ~32'h3), mode_tag(em), req_addr, (first + 4*k) & ~32'h3);
               chk(req_idx == idxs[k], "R6 index order", req_idx, idxs[k]);
            end else
               chk(0, "R6 extra beat", k, n);
            chk(req_write == !ld, "R13 direction", req_write, !ld);
            if (inject && k == 0 && vcyc == 1) begin
               // R12: new arguments while busy must be ignored
               start = 1'b1; base = 32'h5555_0000; reg_mask = 16'hFFFF; mode = 2'd3;
            end
            req_ready = stall ? cyc[0] : 1'b1;
            if (req_ready) k++;
         end else
            req_ready = 1'b0;
      end
      req_ready = 1'b0;
      chk(seen_done, "R13 completion seen", seen_done, 1);
      chk(k == n, "R6 beat count", k, n);
      chk(!busy, "R13 busy low at done", busy, 0);
      if (!stall) chk(vcyc == n, "R1 beat cycles", vcyc, n);
      chk(new_base == exp_nb, n == 0 ? "R10 base unchanged" : "R8 new base", new_base, exp_nb);
      chk(wb_valid == wb, "R8 writeback flag", wb_valid, wb);
      nb_out = new_base;
      @(negedge clk);
      chk(!done && !busy, inject ? "R12 no restart" : "R13 done one cycle", {done, busy}, 0);
   endtask

   initial begin
      logic [AW-1:0] nb;
      logic [NR-1:0] masks[6] = '{16'h0000, 16'h0001, 16'h8000, 16'h000E, 16'hA5A5, 16'hFFFF};
      repeat (3) @(negedge clk);
      chk(!busy && !done && !req_valid, "R13 reset state", {busy, done, req_valid}, 0);
      rst_n = 1'b1;
      // R2..R5, R6, R7, R8, R10, R11 sweep
      for (int md = 0; md < 4; md++)
         for (int mi = 0; mi < 6; mi++)
            for (int wb = 0; wb < 2; wb++)
               for (int st = 0; st < 2; st++)
                  run(32'h0008_0010 + 32'(md*3), masks[mi], md, 0, 0, bit'(md[0]), bit'(wb),
                      bit'(st), 0, nb);
      // worked examples, aligned base
      run(32'h0008_0010, 16'h000E, 0, 0, 0, 1, 1, 0, 0, nb);
      chk(nb == 32'h0008_001C, "R2 ascending-after base", nb, 32'h0008_001C);
      run(32'h0000_9000, 16'h000E, 1, 0, 0, 0, 1, 0, 0, nb);
      chk(nb == 32'h0000_900C, "R3 store ascending-before base", nb, 32'h900C);
      run(nb, 16'h000E, 2, 0, 0, 1, 1, 1, 0, nb);
      chk(nb == 32'h0000_9000, "R4 reload restores base", nb, 32'h9000);
      // R9 stack kinds, pop and push
      for (int kd = 0; kd < 4; kd++)
         for (int ld = 0; ld < 2; ld++)
            run(32'h0001_0040, 16'h00F1, 3 - kd, 1, kd, bit'(ld), 1, bit'(kd[0]), 0, nb);
      // R12 start while busy
      run(32'h0002_0000, 16'h0C03, 1, 0, 0, 1, 1, 1, 1, nb);
      run(32'h0002_0000, 16'h0006, 2, 0, 0, 0, 0, 0, 1, nb);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(PERIOD * 150000);
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule